// File: doc/BRIEF.md
# Special-purpose register access unit

This block services the move-to and move-from special-purpose register commands of a small 32-bit RISC core. A command carries a 16-bit register address, a write strobe, write data and a fallback value. The address is the register group shifted left by 11 bits plus the register number inside that group. The block stores the supervision and exception-state registers. It also stores the interrupt mask and interrupt status registers, and one way of match and translate entries for both the data TLB and the instruction TLB. Read data is combinational from the current state.

The register file is not plain storage. The supervision register always keeps its fixed-one bit set. A change to the translation-enable or mode bits produces a one-cycle full-flush pulse. Clearing the valid bit of a TLB match entry produces a one-cycle single-entry invalidate pulse, and that pulse carries the page the entry held before the write. A write to the interrupt mask ORs into it, and a write to the interrupt status clears the bits it names. The two timer registers are forwarded to a side port. Any address the block does not hold returns the caller's fallback value unchanged. This includes TLB ways 1 to 3 and entries beyond the configured depth.

Top module: `spr_unit`

## Requirements
- R1: The address is group*2048 + number. Group 0 holds next PC (16), previous PC (18), exception PC (32), exception effective address (48) and exception supervision register (64). Each of these reads back the last value written. All of them reset to 0.
- R2: The version register (group 0, number 0) resets to VER_RESET and is writable. A read returns the stored value ANDed with VER_MASK.
- R3: The supervision register (group 0, number 17) resets to 0x00008001. A write stores the data with bit 15 forced to 1, and sr_o always shows the stored value.
- R4: tlb_flush_o is high for exactly the one cycle after the edge of a supervision write whose data differs from the old value in bit 0, bit 5 or bit 6. A supervision write that leaves those three bits unchanged gives no pulse.
- R5: Data TLB entry i is at group 1 and instruction TLB entry i is at group 2. In each group the match register is number 512+i and the translate register is number 640+i, for i below TLB_DEPTH. Each reads back the last value written and resets to 0.
- R6: A match register write with data bit 0 equal to 0 raises tlb_inv_o for one cycle after the edge. During that cycle tlb_inv_page_o is the entry's previous match value with its low PAGE_BITS bits cleared, and tlb_inv_iside_o is 1 for the instruction TLB. A match write with bit 0 equal to 1 gives no pulse.
- R7: In groups 1 and 2, numbers 768 to 1535 (ways 1 to 3) and entry numbers at or above TLB_DEPTH change no state when written. A read of them returns cmd_fallback_i.
- R8: A write to the interrupt mask (group 9, number 0) ORs the data into the mask.
- R9: Each cycle the interrupt status (group 9, number 2) is updated to (old AND NOT clear) OR irq_set_i. Here clear is the write data of a status write in that cycle and 0 otherwise, so a line set in the same cycle stays set.
- R10: The read-only registers (group 0, numbers 1 to 4) return their parameter values and ignore writes. Every other unmatched address returns cmd_fallback_i.
- R11: Group 10 numbers 0 and 1 go to the timer port. A read returns tmr_rdata_i. A write raises tmr_we_o combinationally with tmr_idx_o equal to number bit 0.
- R12: When cmd_valid_i is 0 no register changes and no pulse is produced. cmd_rdata_o still reflects cmd_addr_i.
- R13: irq_o is high when any bit is set in both the interrupt status and the interrupt mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present |
| cmd_we_i | input | 1 | 1 = move-to (write), 0 = move-from (read) |
| cmd_addr_i | input | 16 | Register address, group in [15:11], number in [10:0] |
| cmd_wdata_i | input | 32 | Write data |
| cmd_fallback_i | input | 32 | Value returned for unmatched reads |
| cmd_rdata_o | output | 32 | Read data for cmd_addr_i |
| sr_o | output | 32 | Current supervision register |
| tlb_flush_o | output | 1 | Full TLB flush pulse |
| tlb_inv_o | output | 1 | Single-entry invalidate pulse |
| tlb_inv_iside_o | output | 1 | Invalidate targets the instruction TLB |
| tlb_inv_page_o | output | 32 | Page of the invalidated entry |
| irq_set_i | input | N_IRQ | Interrupt lines that set status bits |
| irq_o | output | 1 | Unmasked interrupt pending |
| tmr_we_o | output | 1 | Timer register write strobe |
| tmr_idx_o | output | 1 | Timer register select (0 mode, 1 count) |
| tmr_wdata_o | output | 32 | Timer write data |
| tmr_rdata_i | input | 32 | Timer read data for tmr_idx_o |

## Verification
The hardest case to reach is an invalidate pulse that carries a meaningful page. It needs a valid match value already stored at an index, followed by a second write to the same index with bit 0 clear. The invalidate must then report the old page rather than the new data. The stimulus first loads valid entries at the first and last index of both TLBs, then clears them. Random traffic over a small address pool repeatedly revisits the same entries with random valid bits. A second hard case is a status clear in the same cycle as an incoming interrupt on the same line. The directed sequence creates that collision, and random irq_set_i bursts overlap random status writes.

// File: rtl/spr_pkg.sv
package spr_pkg;
  localparam int SPR_ADDR_W = 16;
  localparam int SPR_GRP_W  = 5;
  localparam int SPR_NUM_W  = 11;

  localparam logic [SPR_GRP_W-1:0] GRP_SYS  = 5'd0;
  localparam logic [SPR_GRP_W-1:0] GRP_DTLB = 5'd1;
  localparam logic [SPR_GRP_W-1:0] GRP_PIC  = 5'd9;
  localparam logic [SPR_GRP_W-1:0] GRP_TMR  = 5'd10;

  localparam logic [SPR_NUM_W-1:0] N_VER    = 11'd0;
  localparam logic [SPR_NUM_W-1:0] N_UNIT   = 11'd1;
  localparam logic [SPR_NUM_W-1:0] N_CPUCFG = 11'd2;
  localparam logic [SPR_NUM_W-1:0] N_DCFG   = 11'd3;
  localparam logic [SPR_NUM_W-1:0] N_ICFG   = 11'd4;
  localparam logic [SPR_NUM_W-1:0] N_NPC    = 11'd16;
  localparam logic [SPR_NUM_W-1:0] N_SR     = 11'd17;
  localparam logic [SPR_NUM_W-1:0] N_PPC    = 11'd18;
  localparam logic [SPR_NUM_W-1:0] N_EPC    = 11'd32;
  localparam logic [SPR_NUM_W-1:0] N_EEA    = 11'd48;
  localparam logic [SPR_NUM_W-1:0] N_ESR    = 11'd64;
  localparam logic [SPR_NUM_W-1:0] N_MATCH  = 11'd512;
  localparam logic [SPR_NUM_W-1:0] N_XLAT   = 11'd640;
  localparam logic [SPR_NUM_W-1:0] N_PMASK  = 11'd0;
  localparam logic [SPR_NUM_W-1:0] N_PSTAT  = 11'd2;

  localparam int SR_SM  = 0;
  localparam int SR_DME = 5;
  localparam int SR_IME = 6;
  localparam int SR_FO  = 15;
  localparam logic [31:0] SR_RESET      = 32'h0000_8001;
  localparam logic [31:0] SR_FLUSH_BITS = (32'd1 << SR_SM) | (32'd1 << SR_DME) | (32'd1 << SR_IME);

  typedef struct packed {
    logic                 wr;
    logic [SPR_NUM_W-1:0] num;
    logic [31:0]          wdata;
  } spr_wr_t;
endpackage

// File: rtl/spr_sys_regs.sv
module spr_sys_regs
  import spr_pkg::*;
#(
  parameter logic [31:0] VER_RESET  = 32'h1300_0005,
  parameter logic [31:0] VER_MASK   = 32'hFF00_003F,
  parameter logic [31:0] UPR_VAL    = 32'h0000_071D,
  parameter logic [31:0] CPUCFG_VAL = 32'h0000_0020,
  parameter logic [31:0] DCFG_VAL   = 32'h0000_0018,
  parameter logic [31:0] ICFG_VAL   = 32'h0000_0018
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  spr_wr_t     cmd_i,
  output logic        hit_o,
  output logic [31:0] rdata_o,
  output logic [31:0] sr_o,
  output logic        flush_o
);
  logic [31:0] ver_q, npc_q, sr_q, ppc_q, epc_q, eea_q, esr_q;
  logic        flush_q;
  logic        wr_sr;

  assign wr_sr = cmd_i.wr && (cmd_i.num == N_SR);

  always_comb begin
    hit_o   = 1'b1;
    rdata_o = '0;
    case (cmd_i.num)
      N_VER:    rdata_o = ver_q & VER_MASK;
      N_UNIT:   rdata_o = UPR_VAL;
      N_CPUCFG: rdata_o = CPUCFG_VAL;
      N_DCFG:   rdata_o = DCFG_VAL;
      N_ICFG:   rdata_o = ICFG_VAL;
      N_NPC:    rdata_o = npc_q;
      N_SR:     rdata_o = sr_q;
      N_PPC:    rdata_o = ppc_q;
      N_EPC:    rdata_o = epc_q;
      N_EEA:    rdata_o = eea_q;
      N_ESR:    rdata_o = esr_q;
      default:  hit_o   = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ver_q   <= VER_RESET;
      npc_q   <= '0;
      sr_q    <= SR_RESET;
      ppc_q   <= '0;
      epc_q   <= '0;
      eea_q   <= '0;
      esr_q   <= '0;
      flush_q <= 1'b0;
    end else begin
      flush_q <= wr_sr && (((sr_q ^ cmd_i.wdata) & SR_FLUSH_BITS) != '0);
      if (cmd_i.wr) begin
        case (cmd_i.num)
          N_VER:   ver_q <= cmd_i.wdata;
          N_NPC:   npc_q <= cmd_i.wdata;
          N_SR:    sr_q  <= cmd_i.wdata | (32'd1 << SR_FO);
          N_PPC:   ppc_q <= cmd_i.wdata;
          N_EPC:   epc_q <= cmd_i.wdata;
          N_EEA:   eea_q <= cmd_i.wdata;
          N_ESR:   esr_q <= cmd_i.wdata;
          default: ;
        endcase
      end
    end
  end

  assign sr_o    = sr_q;
  assign flush_o = flush_q;

  p_sr_fixed_one_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_sr |=> sr_o == ($past(cmd_i.wdata) | 32'h0000_8000))
    else $error("supervision write lost fixed-one bit");

  p_flush_cause_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> $past(wr_sr))
    else $error("flush without supervision write");

  p_flush_width_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |=> !flush_o || $past(wr_sr))
    else $error("flush pulse stretched");
endmodule

// File: rtl/spr_tlb_bank.sv
module spr_tlb_bank
  import spr_pkg::*;
#(
  parameter int DEPTH     = 64,
  parameter int PAGE_BITS = 13
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  spr_wr_t     cmd_i,
  output logic        hit_o,
  output logic [31:0] rdata_o,
  output logic        inv_o,
  output logic [31:0] inv_page_o
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [31:0] PAGE_MASK = ~((32'd1 << PAGE_BITS) - 32'd1);

  logic [31:0] match_q [DEPTH];
  logic [31:0] xlat_q  [DEPTH];
  logic [SPR_NUM_W-1:0] m_off, x_off;
  logic [IDX_W-1:0]     m_idx, x_idx;
  logic                 m_hit, x_hit, do_inv;
  logic                 inv_q;
  logic [31:0]          inv_page_q;

  assign m_off = cmd_i.num - N_MATCH;
  assign x_off = cmd_i.num - N_XLAT;
  assign m_hit = (cmd_i.num >= N_MATCH) && ({21'd0, m_off} < 32'(DEPTH));
  assign x_hit = (cmd_i.num >= N_XLAT)  && ({21'd0, x_off} < 32'(DEPTH));
  assign m_idx = m_off[IDX_W-1:0];
  assign x_idx = x_off[IDX_W-1:0];
  assign do_inv = cmd_i.wr && m_hit && !cmd_i.wdata[0];

  assign hit_o   = m_hit || x_hit;
  assign rdata_o = m_hit ? match_q[m_idx] : (x_hit ? xlat_q[x_idx] : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) begin
        match_q[i] <= '0;
        xlat_q[i]  <= '0;
      end
      inv_q      <= 1'b0;
      inv_page_q <= '0;
    end else begin
      inv_q <= do_inv;
      if (do_inv) inv_page_q <= match_q[m_idx] & PAGE_MASK;
      if (cmd_i.wr && m_hit) match_q[m_idx] <= cmd_i.wdata;
      if (cmd_i.wr && x_hit) xlat_q[x_idx]  <= cmd_i.wdata;
    end
  end

  assign inv_o      = inv_q;
  assign inv_page_o = inv_page_q;

  p_inv_cause_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_o |-> $past(cmd_i.wr && m_hit && !cmd_i.wdata[0]))
    else $error("invalidate without clearing match write");

  p_match_readback_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i.wr && m_hit |=> match_q[$past(m_idx)] == $past(cmd_i.wdata))
    else $error("match entry not stored");

  p_page_aligned_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_o |-> (inv_page_o & ~PAGE_MASK) == '0)
    else $error("invalidate page not aligned");
endmodule

// File: rtl/spr_pic.sv
module spr_pic #(
  parameter int N_IRQ = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_mask_i,
  input  logic             wr_stat_i,
  input  logic [31:0]      wdata_i,
  input  logic [N_IRQ-1:0] set_i,
  output logic [N_IRQ-1:0] mask_o,
  output logic [N_IRQ-1:0] stat_o,
  output logic             irq_o
);
  logic [N_IRQ-1:0] mask_q, stat_q, clr;

  assign clr = wr_stat_i ? wdata_i[N_IRQ-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      stat_q <= '0;
    end else begin
      if (wr_mask_i) mask_q <= mask_q | wdata_i[N_IRQ-1:0];
      stat_q <= (stat_q & ~clr) | set_i;  // set beats clear
    end
  end

  assign mask_o = mask_q;
  assign stat_o = stat_q;
  assign irq_o  = |(mask_q & stat_q);

  p_mask_or_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_mask_i |=> (mask_o & $past(wdata_i[N_IRQ-1:0])) == $past(wdata_i[N_IRQ-1:0]))
    else $error("mask write did not set bits");

  p_mask_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (mask_o & $past(mask_o)) == $past(mask_o))
    else $error("mask bit dropped");

  p_stat_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stat_i && (set_i == '0) |=> (stat_o & $past(wdata_i[N_IRQ-1:0])) == '0)
    else $error("status bit survived clear");

  p_stat_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (stat_o & $past(set_i)) == $past(set_i))
    else $error("incoming interrupt lost");
endmodule

// File: rtl/spr_unit.sv
module spr_unit
  import spr_pkg::*;
#(
  parameter int          TLB_DEPTH  = 64,
  parameter int          PAGE_BITS  = 13,
  parameter int          N_IRQ      = 32,
  parameter logic [31:0] VER_RESET  = 32'h1300_0005,
  parameter logic [31:0] VER_MASK   = 32'hFF00_003F,
  parameter logic [31:0] UPR_VAL    = 32'h0000_071D,
  parameter logic [31:0] CPUCFG_VAL = 32'h0000_0020,
  parameter logic [31:0] DCFG_VAL   = 32'h0000_0018,
  parameter logic [31:0] ICFG_VAL   = 32'h0000_0018
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cmd_valid_i,
  input  logic                  cmd_we_i,
  input  logic [SPR_ADDR_W-1:0] cmd_addr_i,
  input  logic [31:0]           cmd_wdata_i,
  input  logic [31:0]           cmd_fallback_i,
  output logic [31:0]           cmd_rdata_o,
  output logic [31:0]           sr_o,
  output logic                  tlb_flush_o,
  output logic                  tlb_inv_o,
  output logic                  tlb_inv_iside_o,
  output logic [31:0]           tlb_inv_page_o,
  input  logic [N_IRQ-1:0]      irq_set_i,
  output logic                  irq_o,
  output logic                  tmr_we_o,
  output logic                  tmr_idx_o,
  output logic [31:0]           tmr_wdata_o,
  input  logic [31:0]           tmr_rdata_i
);
  localparam int N_BANK = 2;  // 0 data side, 1 instruction side

  logic [SPR_GRP_W-1:0] grp;
  logic [SPR_NUM_W-1:0] num;
  logic                 wr, tmr_hit;

  assign grp = cmd_addr_i[SPR_ADDR_W-1:SPR_NUM_W];
  assign num = cmd_addr_i[SPR_NUM_W-1:0];
  assign wr  = cmd_valid_i && cmd_we_i;
  assign tmr_hit = (grp == GRP_TMR) && (num[SPR_NUM_W-1:1] == '0);

  spr_wr_t     sys_cmd;
  logic        sys_hit;
  logic [31:0] sys_rdata;

  assign sys_cmd = '{wr: wr && (grp == GRP_SYS), num: num, wdata: cmd_wdata_i};

  spr_sys_regs #(
    .VER_RESET (VER_RESET),
    .VER_MASK  (VER_MASK),
    .UPR_VAL   (UPR_VAL),
    .CPUCFG_VAL(CPUCFG_VAL),
    .DCFG_VAL  (DCFG_VAL),
    .ICFG_VAL  (ICFG_VAL)
  ) u_sys (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cmd_i  (sys_cmd),
    .hit_o  (sys_hit),
    .rdata_o(sys_rdata),
    .sr_o   (sr_o),
    .flush_o(tlb_flush_o)
  );

  logic [N_BANK-1:0] bank_hit, bank_inv, bank_sel;
  logic [31:0]       bank_rdata [N_BANK];
  logic [31:0]       bank_page  [N_BANK];

  for (genvar b = 0; b < N_BANK; b++) begin : g_bank
    localparam logic [SPR_GRP_W-1:0] BANK_GRP = GRP_DTLB + SPR_GRP_W'(b);
    spr_wr_t bank_cmd;
    assign bank_sel[b] = (grp == BANK_GRP);
    assign bank_cmd = '{wr: wr && bank_sel[b], num: num, wdata: cmd_wdata_i};

    spr_tlb_bank #(
      .DEPTH    (TLB_DEPTH),
      .PAGE_BITS(PAGE_BITS)
    ) u_tlb (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .cmd_i     (bank_cmd),
      .hit_o     (bank_hit[b]),
      .rdata_o   (bank_rdata[b]),
      .inv_o     (bank_inv[b]),
      .inv_page_o(bank_page[b])
    );
  end

  assign tlb_inv_o       = |bank_inv;
  assign tlb_inv_iside_o = bank_inv[1];
  assign tlb_inv_page_o  = bank_inv[1] ? bank_page[1] : bank_page[0];

  logic [N_IRQ-1:0] pic_mask, pic_stat;
  logic             pic_grp;

  assign pic_grp = (grp == GRP_PIC);

  spr_pic #(.N_IRQ(N_IRQ)) u_pic (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_mask_i(wr && pic_grp && (num == N_PMASK)),
    .wr_stat_i(wr && pic_grp && (num == N_PSTAT)),
    .wdata_i  (cmd_wdata_i),
    .set_i    (irq_set_i),
    .mask_o   (pic_mask),
    .stat_o   (pic_stat),
    .irq_o    (irq_o)
  );

  assign tmr_we_o    = wr && tmr_hit;
  assign tmr_idx_o   = num[0];
  assign tmr_wdata_o = cmd_wdata_i;

  always_comb begin
    cmd_rdata_o = cmd_fallback_i;
    if (grp == GRP_SYS) begin
      if (sys_hit) cmd_rdata_o = sys_rdata;
    end else if (bank_sel[0]) begin
      if (bank_hit[0]) cmd_rdata_o = bank_rdata[0];
    end else if (bank_sel[1]) begin
      if (bank_hit[1]) cmd_rdata_o = bank_rdata[1];
    end else if (pic_grp) begin
      if (num == N_PMASK)      cmd_rdata_o = 32'(pic_mask);
      else if (num == N_PSTAT) cmd_rdata_o = 32'(pic_stat);
    end else if (tmr_hit) begin
      cmd_rdata_o = tmr_rdata_i;
    end
  end

  p_inv_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(bank_inv))
    else $error("both TLB sides invalidating");

  p_fallback_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grp > GRP_TMR) |-> cmd_rdata_o == cmd_fallback_i)
    else $error("unmatched group did not return fallback");

  p_idle_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_i |=> $stable(sr_o) && !tlb_flush_o && !tlb_inv_o)
    else $error("idle cycle changed state");

  p_tmr_strobe_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_we_o |-> cmd_valid_i && cmd_we_i)
    else $error("timer strobe without write");
endmodule

// File: tb/spr_unit_tb.sv
module spr_unit_tb;
  localparam int          D     = 64;
  localparam logic [31:0] VRST  = 32'h1300_0005;
  localparam logic [31:0] VMASK = 32'hFF00_003F;
  localparam logic [31:0] UPRV  = 32'h0000_071D;
  localparam logic [31:0] CPUV  = 32'h0000_0020;
  localparam logic [31:0] DCFGV = 32'h0000_0018;
  localparam logic [31:0] ICFGV = 32'h0000_0018;
  localparam int SR_A = 17;
  localparam int PM_A = (9 << 11);
  localparam int PS_A = (9 << 11) + 2;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, v, we, flush, inv, iside, irq, twe, tidx;
  logic [15:0] addr;
  logic [31:0] wd, fb, rd, sr, page, twd, trd, set;

  spr_unit #(
    .TLB_DEPTH(D), .PAGE_BITS(13), .N_IRQ(32), .VER_RESET(VRST), .VER_MASK(VMASK),
    .UPR_VAL(UPRV), .CPUCFG_VAL(CPUV), .DCFG_VAL(DCFGV), .ICFG_VAL(ICFGV)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(v), .cmd_we_i(we), .cmd_addr_i(addr),
    .cmd_wdata_i(wd), .cmd_fallback_i(fb), .cmd_rdata_o(rd), .sr_o(sr),
    .tlb_flush_o(flush), .tlb_inv_o(inv), .tlb_inv_iside_o(iside), .tlb_inv_page_o(page),
    .irq_set_i(set), .irq_o(irq), .tmr_we_o(twe), .tmr_idx_o(tidx), .tmr_wdata_o(twd),
    .tmr_rdata_i(trd)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit [31:0] st [int];
  bit        p_flush, p_inv, p_iside;
  bit [31:0] p_page;

  function automatic int A(int g, int n);
    return (g << 11) + n;
  endfunction

  function automatic bit [31:0] get(int a);
    if (st.exists(a)) return st[a];
    if (a == SR_A) return 32'h0000_8001;
    if (a == 0) return VRST;
    return 32'h0;
  endfunction

  function automatic bit in_tlb(int n);
    return (n >= 512 && n < 512 + D) || (n >= 640 && n < 640 + D);
  endfunction

  function automatic bit is_g0_rw(int n);
    return n == 0 || n == 16 || n == 17 || n == 18 || n == 32 || n == 48 || n == 64;
  endfunction

  function automatic bit [31:0] mread(int a, bit [31:0] f);
    int g = a >> 11;
    int n = a & 'h7ff;
    case (g)
      0: begin
        if (n == 0) return get(a) & VMASK;
        if (n == 1) return UPRV;
        if (n == 2) return CPUV;
        if (n == 3) return DCFGV;
        if (n == 4) return ICFGV;
        if (is_g0_rw(n)) return get(a);
        return f;
      end
      1, 2: return in_tlb(n) ? get(a) : f;
      9: return (n == 0 || n == 2) ? get(a) : f;
      10: return (n < 2) ? trd : f;
      default: return f;
    endcase
  endfunction

  function automatic string tag(int a);
    int g = a >> 11;
    int n = a & 'h7ff;
    if (g == 0) begin
      if (n == 0) return "R2";
      if (n == SR_A) return "R3";
      if (is_g0_rw(n)) return "R1";
      return "R10";
    end
    if (g == 1 || g == 2) return in_tlb(n) ? "R5" : "R7";
    if (g == 9 && n == 0) return "R8";
    if (g == 9 && n == 2) return "R9";
    if (g == 10 && n < 2) return "R11";
    return "R10";
  endfunction

  task automatic chk(string r, bit [31:0] act, bit [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", r, act, exp, $time);
    end
  endtask

  task automatic step(bit sv, bit sw, int a, bit [31:0] swd, bit [31:0] sfb, bit [31:0] sset);
    int g = a >> 11;
    int n = a & 'h7ff;
    bit [31:0] clr;
    @(negedge clk);
    v = sv; we = sw; addr = 16'(a); wd = swd; fb = sfb; set = sset;
    trd = 32'hC0DE_0000 ^ {16'h0, addr};
    #2;
    chk(tag(a), rd, mread(a, sfb));
    chk("R4", {31'h0, flush}, {31'h0, p_flush});
    chk("R6", {31'h0, inv}, {31'h0, p_inv});
    if (p_inv) begin
      chk("R6", page, p_page);
      chk("R6", {31'h0, iside}, {31'h0, p_iside});
    end
    chk("R3", sr, get(SR_A));
    chk("R13", {31'h0, irq}, {31'h0, |(get(PM_A) & get(PS_A))});
    chk("R11", {31'h0, twe}, {31'h0, sv && sw && g == 10 && n < 2});
    if (g == 10 && n < 2) chk("R11", {31'h0, tidx}, n & 1);
    // model update for the coming edge; R12: nothing when sv is 0
    p_flush = 0;
    p_inv = 0;
    clr = 0;
    if (sv && sw) begin
      if (g == 0 && is_g0_rw(n)) begin
        if (n == SR_A) begin
          p_flush = ((get(a) ^ swd) & 32'h0000_0061) != 0;
          st[a] = swd | 32'h0000_8000;
        end else st[a] = swd;
      end else if ((g == 1 || g == 2) && in_tlb(n)) begin
        if (n < 640 && !swd[0]) begin
          p_inv = 1;
          p_page = get(a) & 32'hFFFF_E000;
          p_iside = (g == 2);
        end
        st[a] = swd;
      end else if (a == PM_A) st[a] = get(a) | swd;
      else if (a == PS_A) clr = swd;
    end
    st[PS_A] = (get(PS_A) & ~clr) | sset;
  endtask

  initial begin : watchdog
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    int pool[$];
    rst_n = 0; v = 0; we = 0; addr = 16'(SR_A); wd = 0; fb = 32'hFFFF_FFFF; set = 0;
    trd = 0;
    st.delete();
    p_flush = 0; p_inv = 0; p_iside = 0; p_page = 0;
    repeat (2) @(negedge clk);
    #2;
    chk("R3", rd, 32'h0000_8001);
    chk("R4", {31'h0, flush}, 32'h0);
    chk("R6", {31'h0, inv}, 32'h0);
    chk("R13", {31'h0, irq}, 32'h0);
    @(negedge clk);
    rst_n = 1;

    // R1 exception/PC registers
    step(1, 1, 16, 32'h0000_1000, 0, 0);
    step(1, 1, 18, 32'h0000_0FFC, 0, 0);
    step(1, 1, 32, 32'hDEAD_BEEF, 0, 0);
    step(1, 1, 48, 32'h8000_0004, 0, 0);
    step(1, 1, 64, 32'h0000_8207, 0, 0);
    step(1, 0, 16, 0, 32'h1111_1111, 0);
    step(1, 0, 32, 0, 32'h1111_1111, 0);
    step(1, 0, 64, 0, 32'h1111_1111, 0);
    // R2 version mask
    step(1, 0, 0, 0, 0, 0);
    step(1, 1, 0, 32'hFFFF_FFFF, 0, 0);
    step(1, 0, 0, 0, 0, 0);
    // R3/R4 supervision: SM change, same bits, DME, IME, non-flush bit
    step(1, 1, SR_A, 32'h0000_0000, 0, 0);
    step(1, 1, SR_A, 32'h0000_0004, 0, 0);
    step(1, 1, SR_A, 32'h0000_0024, 0, 0);
    step(1, 1, SR_A, 32'h0000_0064, 0, 0);
    step(1, 1, SR_A, 32'h0000_8264, 0, 0);
    step(1, 0, SR_A, 0, 0, 0);
    // R12 invalid write: no state change, no pulse
    step(0, 1, SR_A, 32'h0000_0001, 0, 0);
    step(0, 1, 16, 32'h5555_5555, 0, 0);
    step(1, 0, 16, 0, 0, 0);
    // R5/R6 TLB first and last index, both sides
    step(1, 1, A(1, 512), 32'h1234_5671, 0, 0);
    step(1, 1, A(1, 640), 32'h0ABC_D0C0, 0, 0);
    step(1, 1, A(2, 512 + D - 1), 32'hFFFF_FFFF, 0, 0);
    step(1, 1, A(2, 640 + D - 1), 32'h0000_00FF, 0, 0);
    step(1, 0, A(1, 512), 0, 0, 0);
    step(1, 1, A(1, 512), 32'h0000_0000, 0, 0);
    step(1, 1, A(2, 512 + D - 1), 32'h0000_2222, 0, 0);
    step(1, 1, A(1, 513), 32'h0000_4001, 0, 0);
    step(1, 0, A(2, 640 + D - 1), 0, 0, 0);
    // R7 other ways and beyond depth
    step(1, 1, A(1, 768), 32'hAAAA_AAAA, 0, 0);
    step(1, 0, A(1, 768), 0, 32'h7777_0000, 0);
    step(1, 1, A(2, 1535), 32'hAAAA_AAAA, 0, 0);
    step(1, 0, A(2, 1535), 0, 32'h7777_0001, 0);
    step(1, 1, A(1, 512 + D), 32'h0000_0000, 0, 0);
    step(1, 0, A(1, 512 + D), 0, 32'h7777_0002, 0);
    step(1, 0, A(2, 640 + D), 0, 32'h7777_0003, 0);
    // R8/R9/R13 interrupts
    step(1, 1, PM_A, 32'h0000_00F0, 0, 0);
    step(1, 1, PM_A, 32'h0000_0F00, 0, 0);
    step(1, 0, PM_A, 0, 0, 32'h0000_0011);
    step(1, 0, PS_A, 0, 0, 0);
    step(1, 1, PS_A, 32'h0000_0011, 0, 32'h0000_0010);
    step(1, 0, PS_A, 0, 0, 0);
    step(1, 1, PS_A, 32'hFFFF_FFFF, 0, 0);
    step(1, 0, PS_A, 0, 0, 0);
    // R10 read-only and unmatched
    step(1, 1, 1, 32'h0, 0, 0);
    step(1, 0, 1, 0, 0, 0);
    step(1, 0, 4, 0, 0, 0);
    step(1, 0, 5, 0, 32'h0BAD_F00D, 0);
    step(1, 0, A(5, 3), 0, 32'h0BAD_F00E, 0);
    step(1, 0, A(31, 2047), 0, 32'h0BAD_F00F, 0);
    step(1, 0, A(9, 1), 0, 32'h0BAD_F010, 0);
    // R11 timer port
    step(1, 1, A(10, 0), 32'h4000_0010, 0, 0);
    step(1, 1, A(10, 1), 32'h0000_0123, 0, 0);
    step(1, 0, A(10, 1), 0, 0, 0);
    step(1, 1, A(10, 2), 32'h1, 32'h9999_0000, 0);

    pool = '{0, 1, 2, 3, 4, 16, 17, 18, 32, 48, 64, 5, 100,
             A(1, 512), A(1, 513), A(1, 512 + D - 1), A(1, 640), A(1, 640 + D - 1),
             A(1, 512 + D), A(1, 768), A(1, 1535),
             A(2, 512), A(2, 520), A(2, 512 + D - 1), A(2, 641), A(2, 900),
             PM_A, A(9, 1), PS_A, A(10, 0), A(10, 1), A(10, 2), A(6, 0), A(31, 7)};
    for (int k = 0; k < 3000; k++) begin
      int a = pool[$urandom_range(pool.size() - 1)];
      bit sv = ($urandom_range(7) != 0);
      bit sw = $urandom_range(1) == 1;
      bit [31:0] swd = $urandom;
      bit [31:0] sset = ($urandom_range(3) == 0) ? ($urandom & 32'h0000_F00F) : 32'h0;
      step(sv, sw, a, swd, $urandom, sset);
    end
    step(0, 0, 0, 0, 0, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule